// File: doc/BRIEF.md
# Terminal-Count Counter with Preloaded Seed

This block counts edges of its clock on which the enable is active and raises a single flag when a fixed number of such edges has passed since reset. The count is fixed when the block is built, not loaded at run time. The count must be at least 2 and at most 65534; a value outside that range stops elaboration. Parameters choose which clock edge is active, the active level of the enable, whether the reset acts at once or only at an enabled edge, the active level of the flag, the repeat behaviour and the register arithmetic.

There is no comparator against the count. Reset loads a seed that is worked out at elaboration. The seed is chosen so that the state register reaches all-zero after exactly the programmed number of enabled edges, and the flag is a decode of that all-zero state. The register can use one of three kinds of arithmetic:

- a binary up-counter;
- a binary down-counter;
- a shift register that shifts toward the least significant bit. For counts below 6 it refills its top bit with the inverse of the bit shifted out (a twisted ring). For counts of 6 and above it uses a maximal-length XNOR feedback, so the state that cannot be reached is all-ones and all-zero stays in the sequence.

There are two repeat behaviours. In the free-running behaviour, the register runs on after the first hit without any reload. In the repeating behaviour, the terminal state reloads the register so that the flag recurs at the programmed interval.

Top module: `tc_counter`

## Requirements
- R1: The state advances on the rising clock edge when CLK_NEG is 0 and on the falling clock edge when CLK_NEG is 1.
- R2: An edge at which the enable is inactive changes neither the state nor the flag. The enable is active when high if EN_LOW is 0, and active when low if EN_LOW is 1.
- R3: After reset the flag is inactive for the first COUNT-1 enabled edges. It becomes active right after the COUNT-th enabled edge.
- R4: With MODE = MODE_WAIT, the flag recurs every P enabled edges after the first hit.
  - For the up and down styles, P is 2^n, where n is the smallest width with 2^n > COUNT.
  - For the shift style with COUNT of 6 or more, P is 2^n-1, where n is the smallest width with 2^n-1 > COUNT.
  - For the shift style with COUNT below 6, P is 2n, where n = COUNT/2+1.
- R5: With MODE = MODE_MOD, the flag is active after every enabled edge whose count since reset is a multiple of COUNT, and inactive after all other enabled edges.
- R6: With RST_SYNC = 0, driving rst_n low clears the flag at once without any clock edge, and the flag stays inactive while rst_n is low.
- R7: With RST_SYNC = 1, rst_n low acts only at an enabled edge. At an edge with the enable inactive, it leaves the state and the flag unchanged.
- R8: The flag is high when active if OUT_LOW is 0, and low when active if OUT_LOW is 1.
- R9: The flag stays active through any number of disabled edges and drops at the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; the active edge is chosen by CLK_NEG |
| en | input | 1 | Count enable; the active level is chosen by EN_LOW |
| rst_n | input | 1 | Active-low reset; acts at once or only at an enabled edge, as chosen by RST_SYNC |
| tc | output | 1 | Terminal-count flag; the active level is chosen by OUT_LOW |

## Verification
The flag is a decode of the state register, so it changes at the enabled edge that completes a count and not one cycle later. The bench therefore samples one time unit after every active edge and compares the flag against a count of enabled edges that it keeps itself. The immediate reset is checked one time unit after rst_n falls, with no clock edge in between. The edge-qualified reset is checked across one disabled edge and then one enabled edge. The falling-edge instance is clocked by an inverted copy of the bench clock, so its edges line up with the sampling used for all the other instances.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  localparam int MAXW = 16;

  typedef logic [MAXW-1:0] word_t;

  typedef enum logic [1:0] {
    STYLE_LFSR = 2'd0,
    STYLE_INC  = 2'd1,
    STYLE_DEC  = 2'd2
  } style_e;

  typedef enum logic {
    MODE_WAIT = 1'b0,
    MODE_MOD  = 1'b1
  } mode_e;

  // Arithmetic actually built: the shift style splits by count.
  typedef enum logic [1:0] {
    K_INC  = 2'd0,
    K_DEC  = 2'd1,
    K_JOHN = 2'd2,
    K_POLY = 2'd3
  } kind_e;

  function automatic kind_e kind_of(style_e s, int c);
    if (s == STYLE_INC) return K_INC;
    if (s == STYLE_DEC) return K_DEC;
    if (c < 6) return K_JOHN;
    return K_POLY;
  endfunction

  // Narrowest register whose cycle strictly exceeds the count,
  // so the seed is never the terminal state itself.
  function automatic int reg_width(kind_e k, int c);
    int w;
    if (k == K_JOHN) return c / 2 + 1;
    if (k == K_POLY) begin
      w = 3;
      while (((1 << w) - 1) <= c) w++;
      return w;
    end
    w = 1;
    while ((1 << w) <= c) w++;
    return w;
  endfunction

  function automatic word_t width_mask(int w);
    word_t m;
    m = '0;
    for (int i = 0; i < w; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Feedback tap set, bit (t-1) set for stage t, stage 1 nearest the input.
  function automatic word_t tap_stages(int w);
    case (w)
      3:       return 16'h0006;
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0829;
      13:      return 16'h100D;
      14:      return 16'h2015;
      15:      return 16'h6000;
      default: return 16'hD008;
    endcase
  endfunction

  // Map stage numbers to register bits: stage t sits at bit w-t.
  function automatic word_t tap_mask(int w);
    word_t p;
    word_t m;
    p = tap_stages(w);
    m = '0;
    for (int i = 0; i < w; i++) begin
      if (p[i]) m[w-1-i] = 1'b1;
    end
    return m;
  endfunction

  function automatic word_t step_fwd(kind_e k, int w, word_t s);
    word_t wm;
    word_t r;
    logic  b;
    wm = width_mask(w);
    case (k)
      K_INC:  r = (s + 16'd1) & wm;
      K_DEC:  r = (s - 16'd1) & wm;
      K_JOHN: begin
        b = ~s[0];
        r = (s >> 1) | (word_t'(b) << (w - 1));
      end
      default: begin
        b = ~^(s & tap_mask(w));
        r = (s >> 1) | (word_t'(b) << (w - 1));
      end
    endcase
    return r;
  endfunction

  // Inverse of one shift step; only used for the shift kinds.
  function automatic word_t step_back(kind_e k, int w, word_t s);
    word_t p;
    logic  x;
    p = (s << 1) & width_mask(w);
    if (k == K_JOHN) begin
      p[0] = ~s[w-1];
    end else begin
      x    = ^(p & tap_mask(w) & 16'hFFFE);
      p[0] = ~s[w-1] ^ x;
    end
    return p;
  endfunction

  function automatic word_t seed_of(kind_e k, int w, int c);
    word_t s;
    if (k == K_INC) return ((width_mask(w) - word_t'(c)) + 16'd1) & width_mask(w);
    if (k == K_DEC) return word_t'(c);
    s = '0;
    for (int i = 0; i < c; i++) s = step_back(k, w, s);
    return s;
  endfunction

endpackage

// File: rtl/tcc_step.sv
module tcc_step #(
  parameter tcc_pkg::kind_e KIND      = tcc_pkg::K_INC,
  parameter int unsigned    W         = 4,
  parameter bit             RELOAD_EN = 1'b0,
  parameter logic [W-1:0]   RELOAD    = '0
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);

  logic [W-1:0] adv;

  if (KIND == tcc_pkg::K_INC) begin : g_inc
    always_comb adv = cur + 1'b1;
  end else if (KIND == tcc_pkg::K_DEC) begin : g_dec
    always_comb adv = cur - 1'b1;
  end else if (KIND == tcc_pkg::K_JOHN) begin : g_john
    always_comb adv = {~cur[0], cur[W-1:1]};
  end else begin : g_poly
    localparam tcc_pkg::word_t TM_FULL = tcc_pkg::tap_mask(W);
    localparam logic [W-1:0]   TM      = TM_FULL[W-1:0];
    always_comb adv = {~^(cur & TM), cur[W-1:1]};
  end

  // Repeating behaviour: the terminal state jumps to the state one step past the seed.
  always_comb begin
    if (RELOAD_EN && (cur == '0)) nxt = RELOAD;
    else                          nxt = adv;
  end

endmodule

// File: rtl/tcc_state_reg.sv
module tcc_state_reg #(
  parameter int unsigned  W        = 4,
  parameter logic [W-1:0] SEED     = '0,
  parameter bit           CLK_NEG  = 1'b0,
  parameter bit           RST_SYNC = 1'b0
) (
  input  logic         clk,
  input  logic         en_act,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (!RST_SYNC && !CLK_NEG) begin : g_async_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= SEED;
      else if (en_act) q <= d;
    end
  end else if (!RST_SYNC && CLK_NEG) begin : g_async_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)      q <= SEED;
      else if (en_act) q <= d;
    end
  end else if (!CLK_NEG) begin : g_sync_rise
    always_ff @(posedge clk) begin
      if (en_act) q <= rst_n ? d : SEED;
    end
  end else begin : g_sync_fall
    always_ff @(negedge clk) begin
      if (en_act) q <= rst_n ? d : SEED;
    end
  end

endmodule

// File: rtl/tcc_flag.sv
module tcc_flag #(
  parameter int unsigned W       = 4,
  parameter bit          OUT_LOW = 1'b0
) (
  input  logic [W-1:0] state,
  output logic         tc
);

  logic at_zero;

  always_comb at_zero = (state == '0);
  always_comb tc      = at_zero ^ OUT_LOW;

endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int unsigned     COUNT    = 10,
  parameter tcc_pkg::mode_e  MODE     = tcc_pkg::MODE_WAIT,
  parameter tcc_pkg::style_e STYLE    = tcc_pkg::STYLE_LFSR,
  parameter bit              CLK_NEG  = 1'b0,
  parameter bit              EN_LOW   = 1'b0,
  parameter bit              RST_SYNC = 1'b0,
  parameter bit              OUT_LOW  = 1'b0
) (
  input  logic clk,
  input  logic en,
  input  logic rst_n,
  output logic tc
);

  localparam tcc_pkg::kind_e KIND     = tcc_pkg::kind_of(STYLE, COUNT);
  localparam int unsigned    W        = tcc_pkg::reg_width(KIND, COUNT);
  localparam tcc_pkg::word_t SEED_F   = tcc_pkg::seed_of(KIND, W, COUNT);
  localparam tcc_pkg::word_t RELOAD_F = tcc_pkg::step_fwd(KIND, W, SEED_F);
  localparam logic [W-1:0]   SEED     = SEED_F[W-1:0];
  localparam logic [W-1:0]   RELOAD   = RELOAD_F[W-1:0];
  localparam bit             DO_LOAD  = (MODE == tcc_pkg::MODE_MOD);

  if ((COUNT < 2) || (COUNT > 65534)) begin : g_bad_count
    $error("tc_counter: COUNT must lie in 2..65534");
  end

  logic         en_act;
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  always_comb en_act = en ^ EN_LOW;

  tcc_step #(
    .KIND      (KIND),
    .W         (W),
    .RELOAD_EN (DO_LOAD),
    .RELOAD    (RELOAD)
  ) u_step (
    .cur (st_q),
    .nxt (st_d)
  );

  tcc_state_reg #(
    .W        (W),
    .SEED     (SEED),
    .CLK_NEG  (CLK_NEG),
    .RST_SYNC (RST_SYNC)
  ) u_reg (
    .clk    (clk),
    .en_act (en_act),
    .rst_n  (rst_n),
    .d      (st_d),
    .q      (st_q)
  );

  tcc_flag #(
    .W       (W),
    .OUT_LOW (OUT_LOW)
  ) u_flag (
    .state (st_q),
    .tc    (tc)
  );

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int unsigned     COUNT    = 10,
  parameter tcc_pkg::mode_e  MODE     = tcc_pkg::MODE_WAIT,
  parameter tcc_pkg::style_e STYLE    = tcc_pkg::STYLE_LFSR,
  parameter bit              CLK_NEG  = 1'b0,
  parameter bit              EN_LOW   = 1'b0,
  parameter bit              RST_SYNC = 1'b0,
  parameter bit              OUT_LOW  = 1'b0,
  parameter int unsigned     W        = 4
) (
  input logic         clk,
  input logic         en,
  input logic         rst_n,
  input logic         tc,
  input logic [W-1:0] state
);

  function automatic int unsigned period_of();
    int unsigned p;
    if ((STYLE == tcc_pkg::STYLE_LFSR) && (COUNT < 6)) return 2 * (COUNT / 2 + 1);
    p = 2;
    if (STYLE == tcc_pkg::STYLE_LFSR) begin
      while ((p - 1) <= COUNT) p = p * 2;
      return p - 1;
    end
    while (p <= COUNT) p = p * 2;
    return p;
  endfunction

  localparam int unsigned PER = period_of();

  logic        ck;
  logic        en_act;
  logic        hit;
  int unsigned k;

  assign ck     = clk ^ CLK_NEG;
  assign en_act = en ^ EN_LOW;
  assign hit    = tc ^ OUT_LOW;

  // Enabled edges since the last effective reset.
  always_ff @(posedge ck) begin
    if (!rst_n && (!RST_SYNC || en_act)) k <= 0;
    else if (en_act)                     k <= k + 32'd1;
  end

  assert_idle_hold_R2: assert property (@(posedge ck) disable iff (!rst_n)
    !en_act |=> $stable(state));

  assert_quiet_before_count_R3: assert property (@(posedge ck) disable iff (!rst_n)
    (k < COUNT) |-> !hit);

  assert_hit_at_count_R3: assert property (@(posedge ck) disable iff (!rst_n)
    (k == COUNT) |-> hit);

  if (MODE == tcc_pkg::MODE_WAIT) begin : g_wait
    assert_wait_period_R4: assert property (@(posedge ck) disable iff (!rst_n)
      (k > COUNT) |-> (hit == (((k - COUNT) % PER) == 0)));
  end else begin : g_mod
    assert_modulo_period_R5: assert property (@(posedge ck) disable iff (!rst_n)
      (k > 0) |-> (hit == ((k % COUNT) == 0)));
  end

  if (!RST_SYNC) begin : g_async
    logic armed;
    always_ff @(posedge ck) armed <= 1'b1;
    assert_async_clear_R6: assert property (@(posedge ck)
      (armed && !rst_n) |-> !hit);
  end

endmodule

bind tc_counter tcc_checker #(
  .COUNT    (COUNT),
  .MODE     (MODE),
  .STYLE    (STYLE),
  .CLK_NEG  (CLK_NEG),
  .EN_LOW   (EN_LOW),
  .RST_SYNC (RST_SYNC),
  .OUT_LOW  (OUT_LOW),
  .W        (W)
) u_chk (
  .clk   (clk),
  .en    (en),
  .rst_n (rst_n),
  .tc    (tc),
  .state (st_q)
);

// File: tb/sim_tc_counter.sv
module sim_tc_counter;

  localparam int PERIOD = 10;
  localparam int NI     = 7;

  // Per instance: count, wait period (from R4), repeating, edge-qualified reset, low flag.
  localparam int CNT  [NI] = '{10, 5, 6, 5, 3, 6, 7};
  localparam int PER  [NI] = '{15, 0, 8, 0, 4, 0, 8};
  localparam bit MODV [NI] = '{0, 1, 0, 1, 0, 1, 0};
  localparam bit SYNC [NI] = '{0, 0, 0, 0, 0, 1, 1};
  localparam bit OLOW [NI] = '{0, 0, 0, 0, 0, 1, 0};

  // Stimulus table {rst_n, en, expected flag of instance 1}.
  localparam int NV = 22;
  localparam logic [2:0] VEC [NV] = '{
    3'b010, 3'b110, 3'b110, 3'b100, 3'b110, 3'b110, 3'b111, 3'b101,
    3'b110, 3'b110, 3'b110, 3'b110, 3'b111, 3'b110, 3'b010, 3'b110,
    3'b110, 3'b110, 3'b100, 3'b110, 3'b111, 3'b110
  };

  logic clk = 1'b0;
  logic en = 1'b0;
  logic rst_n = 1'b0;
  logic clk_n;
  logic en_n;
  logic [NI-1:0] tcv;

  int k [NI] = '{0, 0, 0, 0, 0, 0, 0};
  int n_cmp = 0;
  int n_bad = 0;

  assign clk_n = ~clk;
  assign en_n  = ~en;

  always #(PERIOD / 2) clk = ~clk;

  tc_counter #(.COUNT(10), .MODE(tcc_pkg::MODE_WAIT), .STYLE(tcc_pkg::STYLE_LFSR))
    u0 (.clk(clk), .en(en), .rst_n(rst_n), .tc(tcv[0]));
  tc_counter #(.COUNT(5), .MODE(tcc_pkg::MODE_MOD), .STYLE(tcc_pkg::STYLE_INC))
    u1 (.clk(clk), .en(en), .rst_n(rst_n), .tc(tcv[1]));
  tc_counter #(.COUNT(6), .MODE(tcc_pkg::MODE_WAIT), .STYLE(tcc_pkg::STYLE_DEC))
    u2 (.clk(clk), .en(en), .rst_n(rst_n), .tc(tcv[2]));
  tc_counter #(.COUNT(5), .MODE(tcc_pkg::MODE_MOD), .STYLE(tcc_pkg::STYLE_LFSR))
    u3 (.clk(clk), .en(en), .rst_n(rst_n), .tc(tcv[3]));
  tc_counter #(.COUNT(3), .MODE(tcc_pkg::MODE_WAIT), .STYLE(tcc_pkg::STYLE_LFSR))
    u4 (.clk(clk), .en(en), .rst_n(rst_n), .tc(tcv[4]));
  // R1 falling edge on an inverted clock, R2 low enable, R8 low flag, R7 edge-qualified reset.
  tc_counter #(.COUNT(6), .MODE(tcc_pkg::MODE_MOD), .STYLE(tcc_pkg::STYLE_LFSR),
               .CLK_NEG(1'b1), .EN_LOW(1'b1), .RST_SYNC(1'b1), .OUT_LOW(1'b1))
    u5 (.clk(clk_n), .en(en_n), .rst_n(rst_n), .tc(tcv[5]));
  tc_counter #(.COUNT(7), .MODE(tcc_pkg::MODE_WAIT), .STYLE(tcc_pkg::STYLE_INC),
               .RST_SYNC(1'b1))
    u6 (.clk(clk), .en(en), .rst_n(rst_n), .tc(tcv[6]));

  task automatic check(string req, int inst, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s inst %0d: actual %0b expected %0b", req, inst, got, exp);
    end
  endtask

  function automatic bit hit_of(int i, int kk);
    if (kk < CNT[i]) return 1'b0;
    if (MODV[i]) return (kk % CNT[i]) == 0;
    return ((kk - CNT[i]) % PER[i]) == 0;
  endfunction

  function automatic string tag_of(int i, int kk);
    string t;
    if (kk <= CNT[i]) t = "R3";
    else if (MODV[i]) t = "R5";
    else t = "R4";
    if (i == 5) t = {t, "/R1/R2/R8"};
    return t;
  endfunction

  // One active edge: drive mid-cycle, sample 1 unit after the edge.
  task automatic step(bit e, bit r);
    @(negedge clk);
    en    = e;
    rst_n = r;
    @(posedge clk);
    #1;
    for (int i = 0; i < NI; i++) begin
      if (!r && (!SYNC[i] || e)) k[i] = 0;
      else if (e) k[i]++;
      check(tag_of(i, k[i]), i, tcv[i], hit_of(i, k[i]) ^ OLOW[i]);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 50000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R3: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Table walk: R5 repeat, R9 hold through disabled edges, reset inside the run.
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][1], VEC[v][2]);
      check("R5/R9 table", 1, tcv[1], VEC[v][0]);
    end

    // Reset state.
    step(1'b1, 1'b0);
    check("R3 reset state", 0, tcv[0], 1'b0);
    check("R8 reset state", 5, tcv[5], 1'b1);

    // Bring instances 4 and 6 to a hit (both at 7 enabled edges).
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
    check("R4 pre-reset hit", 4, tcv[4], 1'b1);
    check("R3 pre-reset hit", 6, tcv[6], 1'b1);

    // Immediate reset between edges.
    #2;
    rst_n = 1'b0;
    #1;
    check("R6 async clear", 4, tcv[4], 1'b0);
    check("R7 no edge yet", 6, tcv[6], 1'b1);

    // Disabled edge with reset low: edge-qualified reset must not act.
    step(1'b0, 1'b0);
    check("R7 disabled edge", 6, tcv[6], 1'b1);
    check("R6 held low", 4, tcv[4], 1'b0);

    // Enabled edge with reset low: edge-qualified reset acts.
    step(1'b1, 1'b0);
    check("R7 enabled edge", 6, tcv[6], 1'b0);

    // Long run with a gapped enable: wait-mode periods and modulo repeats.
    for (int i = 0; i < 80; i++) step((i % 4) != 3, 1'b1);

    finish_run();
  end

endmodule